// File: doc/BRIEF.md
# In-Order Retirement Buffer with Exception Flush

This block tracks every instruction in flight between decode and retirement. Decode reserves a slot and gets back a tag. Execution units later report results against that tag, in whatever order they finish. Retirement then takes slots strictly from the oldest end, one per cycle. A retiring slot writes either to the architectural register file or to the store path. Because of this, architectural state always reflects a prefix of the program.

When the oldest slot carries a fault, nothing is written for it. The block raises a one-cycle flush request together with that instruction's PC and discards every slot in one step. Everything older has already retired, and nothing younger ever does.

A combinational lookup port searches all live register-writing slots by destination register. When several slots match, it returns the youngest one, so an operand can be taken from the buffer before it becomes architectural.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `rf_we`, `st_valid`, `flush` and `lk_hit` are all 0.
- R2: Each accepted allocation (`alloc_req` with `alloc_ready` high) returns the next tag in sequence, counting up from 0 and wrapping modulo DEPTH. When DEPTH slots are live, `alloc_ready` is 0 and a request is ignored.
- R3: Completions may target any live slot in any order. Retirement takes only the oldest slot, only once it has completed, and at most one slot per cycle.
- R4: When the oldest slot is a completed, fault-free register instruction, `rf_we` is 1 in that cycle, with `rf_waddr` set to its destination and `rf_wdata` set to its result. The slot is freed at the next clock edge.
- R5: When the oldest slot is a completed, fault-free store (`alloc_is_store`=1), `st_valid` is 1 with `st_addr` and `st_data` taken from its completion. `rf_we` stays 0.
- R6: When the oldest slot completed with `cmpl_exc`=1, `flush` is 1 for that cycle and `flush_pc` holds that slot's PC, with `rf_we` and `st_valid` both 0. In the next cycle the buffer is empty and the next tag is 0.
- R7: Slots younger than a faulting slot never retire, even when they had already completed.
- R8: A lookup reports `lk_hit` when a live register slot targets `lk_reg`, choosing the youngest such slot. `lk_ready` shows whether that slot has completed, and `lk_value` is its result when ready and 0 otherwise. Store slots never match.
- R9: A completion aimed at a tag that is not live changes nothing: nothing retires from it, no lookup hits on it, and the next allocation tag is unchanged.
- R10: An allocation and a retirement in the same cycle leave the number of live slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Decode asks for a slot |
| alloc_is_store | input | 1 | New instruction is a store |
| alloc_dst | input | REG_W | Destination register of the new instruction |
| alloc_pc | input | PC_W | PC of the new instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | IDX_W | Tag given to the slot taken this cycle |
| cmpl_valid | input | 1 | An execution unit reports a result |
| cmpl_tag | input | IDX_W | Slot being completed |
| cmpl_value | input | DATA_W | Result, or store data for a store |
| cmpl_addr | input | DATA_W | Store address (ignored for register instructions) |
| cmpl_exc | input | 1 | The instruction faulted |
| lk_reg | input | REG_W | Register searched for forwarding |
| lk_hit | output | 1 | A live slot targets `lk_reg` |
| lk_ready | output | 1 | The matching slot has its result |
| lk_value | output | DATA_W | Forwarded result |
| rf_we | output | 1 | Register file write from retirement |
| rf_waddr | output | REG_W | Register written |
| rf_wdata | output | DATA_W | Value written |
| st_valid | output | 1 | Store released from retirement |
| st_addr | output | DATA_W | Store address |
| st_data | output | DATA_W | Store data |
| flush | output | 1 | Fault at the oldest slot; discard everything |
| flush_pc | output | PC_W | PC of the faulting instruction |

## Verification
The assertions cover occupancy invariants every cycle. The count never passes DEPTH, and allocation is refused while full. The count follows allocations minus retirements. A register write and a store release never occur together, and a flush suppresses both and empties the buffer by the next cycle. Some properties depend on values and program order, and only the directed scenarios can show them. These are that out-of-order completions still retire oldest-first with the right data, and that the youngest matching slot wins a lookup. They also include that completed slots younger than a fault are dropped, and that stray completions to dead tags leave no trace.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    RET_NONE  = 2'd0,
    RET_REG   = 2'd1,
    RET_STORE = 2'd2,
    RET_FLUSH = 2'd3
  } rob_retire_e;

  // Next slot index around a ring of the given size.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned size);
    return (p + 1 == size) ? 0 : p + 1;
  endfunction

  // Distance of a slot from the oldest slot; larger means younger.
  function automatic int unsigned ring_age(input int unsigned idx, input int unsigned oldest,
                                           input int unsigned size);
    return (idx + size - oldest) % size;
  endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count
);
  import rob_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc_fire)  tail <= IDX_W'(ring_next(int'(tail), DEPTH));
      if (retire_fire) head <= IDX_W'(ring_next(int'(head), DEPTH));
      case ({alloc_fire, retire_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel (
  input  logic                 oldest_valid,
  input  logic                 oldest_done,
  input  logic                 oldest_exc,
  input  logic                 oldest_store,
  output rob_pkg::rob_retire_e kind
);
  import rob_pkg::*;

  always_comb begin
    kind = RET_NONE;
    if (oldest_valid && oldest_done) begin
      if (oldest_exc)        kind = RET_FLUSH;
      else if (oldest_store) kind = RET_STORE;
      else                   kind = RET_REG;
    end
  end

endmodule

// File: rtl/rob_fwd_search.sv
module rob_fwd_search #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]  live,
  input  logic [DEPTH-1:0]  is_store,
  input  logic [DEPTH-1:0]  done,
  input  logic [REG_W-1:0]  dst   [DEPTH],
  input  logic [DATA_W-1:0] value [DEPTH],
  input  logic [IDX_W-1:0]  oldest,
  input  logic [REG_W-1:0]  key,
  output logic              hit,
  output logic              ready,
  output logic [DATA_W-1:0] result
);
  import rob_pkg::*;

  logic [DEPTH-1:0] match;
  int unsigned      best_age;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = live[g] && !is_store[g] && (dst[g] == key);
  end

  always_comb begin
    hit      = 1'b0;
    ready    = 1'b0;
    result   = '0;
    best_age = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i] && (!hit || ring_age(i, int'(oldest), DEPTH) > best_age)) begin
        hit      = 1'b1;
        best_age = ring_age(i, int'(oldest), DEPTH);
        ready    = done[i];
        result   = done[i] ? value[i] : '0;
      end
    end
  end

endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic              alloc_is_store,
  input  logic [REG_W-1:0]  alloc_dst,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              cmpl_valid,
  input  logic [IDX_W-1:0]  cmpl_tag,
  input  logic [DATA_W-1:0] cmpl_value,
  input  logic [DATA_W-1:0] cmpl_addr,
  input  logic              cmpl_exc,
  input  logic [REG_W-1:0]  lk_reg,
  output logic              lk_hit,
  output logic              lk_ready,
  output logic [DATA_W-1:0] lk_value,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic              flush,
  output logic [PC_W-1:0]   flush_pc
);
  import rob_pkg::*;

  // Slot storage
  logic [DEPTH-1:0]  e_live, e_done, e_exc, e_store;
  logic [REG_W-1:0]  e_dst  [DEPTH];
  logic [DATA_W-1:0] e_val  [DEPTH];
  logic [DATA_W-1:0] e_addr [DEPTH];
  logic [PC_W-1:0]   e_pc   [DEPTH];

  // Named internal events
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             alloc_fire, retire_fire, cmpl_fire;
  rob_retire_e      kind;

  assign alloc_ready = (count < CNT_W'(DEPTH)) && !flush;
  assign alloc_fire  = alloc_req && alloc_ready;
  assign alloc_tag   = tail;
  assign cmpl_fire   = cmpl_valid && e_live[cmpl_tag] && !flush;

  rob_retire_sel u_sel (
    .oldest_valid (e_live[head]),
    .oldest_done  (e_done[head]),
    .oldest_exc   (e_exc[head]),
    .oldest_store (e_store[head]),
    .kind         (kind)
  );

  assign rf_we       = (kind == RET_REG);
  assign st_valid    = (kind == RET_STORE);
  assign flush       = (kind == RET_FLUSH);
  assign retire_fire = rf_we || st_valid;
  assign rf_waddr    = e_dst[head];
  assign rf_wdata    = e_val[head];
  assign st_addr     = e_addr[head];
  assign st_data     = e_val[head];
  assign flush_pc    = e_pc[head];

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .retire_fire (retire_fire),
    .flush       (flush),
    .head        (head),
    .tail        (tail),
    .count       (count)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic take_g, free_g, fill_g;
    assign take_g = alloc_fire  && (tail == IDX_W'(g));
    assign free_g = retire_fire && (head == IDX_W'(g));
    assign fill_g = cmpl_fire   && (cmpl_tag == IDX_W'(g)) && !free_g;

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        e_live[g]  <= 1'b0;
        e_done[g]  <= 1'b0;
        e_exc[g]   <= 1'b0;
        e_store[g] <= 1'b0;
        e_dst[g]   <= '0;
        e_val[g]   <= '0;
        e_addr[g]  <= '0;
        e_pc[g]    <= '0;
      end else if (take_g) begin
        e_live[g]  <= 1'b1;
        e_done[g]  <= 1'b0;
        e_exc[g]   <= 1'b0;
        e_store[g] <= alloc_is_store;
        e_dst[g]   <= alloc_dst;
        e_pc[g]    <= alloc_pc;
      end else if (free_g) begin
        e_live[g]  <= 1'b0;
        e_done[g]  <= 1'b0;
      end else if (fill_g) begin
        e_done[g]  <= 1'b1;
        e_exc[g]   <= cmpl_exc;
        e_val[g]   <= cmpl_value;
        e_addr[g]  <= cmpl_addr;
      end
    end
  end

  rob_fwd_search #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_fwd (
    .live     (e_live),
    .is_store (e_store),
    .done     (e_done),
    .dst      (e_dst),
    .value    (e_val),
    .oldest   (head),
    .key      (lk_reg),
    .hit      (lk_hit),
    .ready    (lk_ready),
    .result   (lk_value)
  );

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             alloc_fire,
  input logic             retire_fire,
  input logic             alloc_ready,
  input logic             rf_we,
  input logic             st_valid,
  input logic             flush
);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R2
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) == DEPTH) |-> !alloc_ready);

  // R3
  single_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && st_valid));

  // R6
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!rf_we && !st_valid && !alloc_ready));

  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && !flush));

  // R10
  count_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(count) == int'($past(count)) + int'($past(alloc_fire))
                              - int'($past(retire_fire)));

endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .count       (count),
  .alloc_fire  (alloc_fire),
  .retire_fire (retire_fire),
  .alloc_ready (alloc_ready),
  .rf_we       (rf_we),
  .st_valid    (st_valid),
  .flush       (flush)
);

// File: tb/sim_rob_core.sv
`timescale 1ns/1ps
module sim_rob_core;
  localparam int DEPTH = 8, REG_W = 5, DATA_W = 32, PC_W = 32;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_req = 0, alloc_is_store = 0;
  logic [REG_W-1:0] alloc_dst = '0;
  logic [PC_W-1:0] alloc_pc = '0;
  logic alloc_ready;
  logic [IDX_W-1:0] alloc_tag;
  logic cmpl_valid = 0, cmpl_exc = 0;
  logic [IDX_W-1:0] cmpl_tag = '0;
  logic [DATA_W-1:0] cmpl_value = '0, cmpl_addr = '0;
  logic [REG_W-1:0] lk_reg = '0;
  logic lk_hit, lk_ready;
  logic [DATA_W-1:0] lk_value;
  logic rf_we, st_valid, flush;
  logic [REG_W-1:0] rf_waddr;
  logic [DATA_W-1:0] rf_wdata, st_addr, st_data;
  logic [PC_W-1:0] flush_pc;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W)) u0 (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Drives one allocation and confirms the tag handed out.
  task automatic do_alloc(input bit st, input int dst, input int pc, input int exp_tag);
    check(alloc_ready == 1, "R2 alloc_ready", alloc_ready, 1);
    check(int'(alloc_tag) == exp_tag, "R2 alloc_tag", alloc_tag, exp_tag);
    alloc_req = 1; alloc_is_store = st; alloc_dst = REG_W'(dst); alloc_pc = PC_W'(pc);
    step();
    alloc_req = 0; alloc_is_store = 0;
  endtask

  task automatic do_cmpl(input int tag, input int val, input int addr, input bit exc);
    cmpl_valid = 1; cmpl_tag = IDX_W'(tag); cmpl_value = DATA_W'(val);
    cmpl_addr = DATA_W'(addr); cmpl_exc = exc;
    step();
    cmpl_valid = 0; cmpl_exc = 0;
  endtask

  task automatic expect_reg_commit(input string req, input int dst, input int val);
    check(rf_we == 1, {req, " rf_we"}, rf_we, 1);
    check(int'(rf_waddr) == dst, {req, " rf_waddr"}, rf_waddr, dst);
    check(int'(rf_wdata) == val, {req, " rf_wdata"}, rf_wdata, val);
    check(st_valid == 0 && flush == 0, {req, " no store/flush"}, {st_valid, flush}, 0);
  endtask

  task automatic expect_idle(input string req);
    check(rf_we == 0 && st_valid == 0 && flush == 0, {req, " idle"},
          {rf_we, st_valid, flush}, 0);
  endtask

  task automatic expect_lookup(input string req, input int r, input bit h, input bit rd,
                               input int v);
    lk_reg = REG_W'(r);
    #0.5;
    check(lk_hit == h, {req, " lk_hit"}, lk_hit, h);
    check(lk_ready == rd, {req, " lk_ready"}, lk_ready, rd);
    check(int'(lk_value) == v, {req, " lk_value"}, lk_value, v);
  endtask

  task automatic t_reset();
    check(alloc_ready == 1, "R1 alloc_ready", alloc_ready, 1);
    check(alloc_tag == 0, "R1 alloc_tag", alloc_tag, 0);
    expect_idle("R1");
    expect_lookup("R1", 0, 0, 0, 0);
  endtask

  // Tags 0..2; completions arrive 2,1,0 and retire 0,1,2.
  task automatic t_out_of_order();
    do_alloc(0, 1, 'h100, 0);
    do_alloc(0, 2, 'h104, 1);
    do_alloc(0, 3, 'h108, 2);
    do_cmpl(2, 'h33, 0, 0);
    expect_idle("R3 head pending");
    do_cmpl(1, 'h22, 0, 0);
    expect_idle("R3 head pending");
    expect_lookup("R8 done slot", 2, 1, 1, 'h22);
    do_cmpl(0, 'h11, 0, 0);
    expect_reg_commit("R4 first", 1, 'h11);
    step();
    expect_reg_commit("R3 second", 2, 'h22);
    step();
    expect_reg_commit("R3 third", 3, 'h33);
    step();
    expect_idle("R3 drained");
  endtask

  // Tag 3 is a store.
  task automatic t_store();
    do_alloc(1, 9, 'h10C, 3);
    expect_lookup("R8 store excluded", 9, 0, 0, 0);
    do_cmpl(3, 'hABCD, 'h8000, 0);
    check(st_valid == 1, "R5 st_valid", st_valid, 1);
    check(st_addr == 'h8000, "R5 st_addr", st_addr, 'h8000);
    check(st_data == 'hABCD, "R5 st_data", st_data, 'hABCD);
    check(rf_we == 0, "R5 rf_we", rf_we, 0);
    step();
    expect_idle("R5 after");
  endtask

  // Tags 4,5 both write r7; tag 6 writes r3.
  task automatic t_forward();
    do_alloc(0, 7, 'h110, 4);
    do_alloc(0, 7, 'h114, 5);
    do_alloc(0, 3, 'h118, 6);
    expect_lookup("R8 pending", 7, 1, 0, 0);
    expect_lookup("R8 miss", 9, 0, 0, 0);
    do_cmpl(5, 'h55, 0, 0);
    expect_lookup("R8 youngest wins", 7, 1, 1, 'h55);
    do_cmpl(6, 'h66, 0, 0);
    expect_lookup("R8 other reg", 3, 1, 1, 'h66);
    do_cmpl(4, 'h44, 0, 0);
    expect_lookup("R8 still youngest", 7, 1, 1, 'h55);
    expect_reg_commit("R4 tag4", 7, 'h44);
    step();
    expect_reg_commit("R4 tag5", 7, 'h55);
    step();
    expect_reg_commit("R4 tag6", 3, 'h66);
    step();
    expect_idle("R4 drained");
  endtask

  // Fill all slots starting at tag 7, then overlap allocation with retirement.
  task automatic t_full();
    for (int k = 0; k < DEPTH; k++) do_alloc(0, 10 + k, 'h200 + 4 * k, (7 + k) % DEPTH);
    check(alloc_ready == 0, "R2 full", alloc_ready, 0);
    alloc_req = 1; alloc_dst = 5'd29;
    step();
    alloc_req = 0;
    check(alloc_ready == 0, "R2 full request ignored", alloc_ready, 0);
    check(alloc_tag == 7, "R2 tag held when full", alloc_tag, 7);
    do_cmpl(0, 'h101, 0, 0);
    do_cmpl(7, 'h100, 0, 0);
    expect_reg_commit("R3 wrap head", 10, 'h100);
    check(alloc_ready == 0, "R2 still full", alloc_ready, 0);
    step();
    expect_reg_commit("R3 wrap next", 11, 'h101);
    do_alloc(0, 30, 'h300, 7);
    expect_idle("R10 head pending");
    check(alloc_ready == 1, "R10 count kept", alloc_ready, 1);
    do_alloc(0, 31, 'h304, 0);
    check(alloc_ready == 0, "R10 full again", alloc_ready, 0);
  endtask

  // Slots 1..6 hold k=2..7 (r12..r17, pc 0x208..0x21C), 7 and 0 hold r30, r31.
  task automatic t_exception();
    do_cmpl(3, 'h55, 0, 0);
    do_cmpl(2, 'hDEAD, 0, 1);
    expect_idle("R6 fault not oldest");
    do_cmpl(1, 'h77, 0, 0);
    expect_reg_commit("R6 older retires", 12, 'h77);
    step();
    check(flush == 1, "R6 flush", flush, 1);
    check(flush_pc == 'h20C, "R6 flush_pc", flush_pc, 'h20C);
    check(rf_we == 0 && st_valid == 0, "R6 no write", {rf_we, st_valid}, 0);
    step();
    expect_idle("R7 younger dropped");
    check(alloc_ready == 1, "R6 empty", alloc_ready, 1);
    check(alloc_tag == 0, "R6 tag restart", alloc_tag, 0);
    expect_lookup("R7 completed younger gone", 14, 0, 0, 0);
    expect_lookup("R7 slot gone", 31, 0, 0, 0);
  endtask

  task automatic t_stray();
    do_cmpl(5, 'h999, 0, 0);
    expect_idle("R9 stray");
    expect_lookup("R9 stray", 16, 0, 0, 0);
    check(alloc_tag == 0, "R9 tag unchanged", alloc_tag, 0);
    step();
    expect_idle("R9 stray later");
    do_alloc(0, 5, 'h400, 0);
    expect_lookup("R9 fresh slot pending", 5, 1, 0, 0);
    do_cmpl(0, 'h99, 0, 0);
    expect_reg_commit("R9 fresh slot", 5, 'h99);
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    t_reset();
    t_out_of_order();
    t_store();
    t_forward();
    t_full();
    t_exception();
    t_stray();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule